// File: doc/BRIEF.md
# Inline Command Interpreter for a Serial Transmit Path

This block sits between a byte FIFO and an asynchronous serializer on the transmit side of a serial port. Software can hide control requests inside the ordinary byte stream. An escape byte starts a short command sequence. The block acts on the command and does not forward those bytes to the line. A command can put the line into a break condition (continuous space level), take it out again, or insert a pause measured in pulses of a free-running tick input. An escaped escape byte stands for one literal zero byte.

Both sides use a valid/ready byte handshake. The output side carries data bytes only. A separate level output tells the serializer to hold the line at space. While a break or a pause is in force, ordinary data waits at the input. Command bytes are still accepted during that time, so a pending break can always be cancelled.

A single enable input switches interpretation off. The block then forwards every byte, zero included, unchanged.

Top module: `txc_interp`

## Requirements
- R1: After a synchronous reset, `brk_level` and `err` are low, no pause is pending, and the parser is idle. A non-zero byte presented with `out_ready` high is accepted at once (`in_ready` high).
- R2: With `cmd_en` low, every byte, 0x00 and 0x81 included, is forwarded unchanged on `out_data`. It transfers in the same cycle that it is accepted at the input.
- R3: With `cmd_en` high, a byte 0x00 in the idle state is an escape. It is accepted even if `out_ready` is low, and it produces no output byte. The next byte accepted is the command code.
- R4: Escape followed by code 0x81 sets `brk_level` high. This takes effect from the clock edge that accepts the code. While `brk_level` is high, data bytes are held: `in_ready` and `out_valid` are both low.
- R5: Escape followed by code 0x83 clears `brk_level` from the edge that accepts the code. Held data then flows again.
- R6: Escape, code 0x82, then a length byte N loads a pause of N tick pulses. Data is held until N clock edges with `tick` high have passed. N = 0 gives no pause.
- R7: Escape followed by a second 0x00 forwards exactly one data byte of value 0x00.
- R8: Escape followed by any code other than 0x00, 0x81, 0x82 or 0x83 forwards neither byte. `err` is then high for exactly the one cycle after the edge that accepts the code.
- R9: Escape, code and length bytes are accepted while a break or a pause is in force.
- R10: `out_valid` is high only while `in_valid` is high. Every output transfer coincides with an input acceptance, and the byte order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_en | input | 1 | 1 = interpret inline commands, 0 = plain pass-through |
| in_valid | input | 1 | Upstream byte available |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Byte is taken at this edge |
| out_valid | output | 1 | Data byte offered to the serializer |
| out_data | output | 8 | Data byte to the serializer |
| out_ready | input | 1 | Serializer takes the byte |
| tick | input | 1 | Pause time base, one pulse per unit |
| brk_level | output | 1 | 1 = hold the line at space (break) |
| err | output | 1 | One-cycle pulse on an unknown command code |

## Verification
The hardest condition to reach is a command arriving while data is already stalled behind a break or a pause. If the stimulus places a data byte before the cancelling command, the port stays blocked for good. The random generator therefore emits break-on, an optional pause, and break-off as one atomic group. Directed cases park a data byte in front of an active break and an active pause, then withdraw it before issuing the release. The tick input is driven as a controlled burst so that the exact edge at which a pause expires can be seen at `in_ready`.

// File: rtl/txc_pkg.sv
package txc_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ESC_CODE   = 8'h00;
    localparam logic [BYTE_W-1:0] OP_BRK_ON  = 8'h81;
    localparam logic [BYTE_W-1:0] OP_DELAY   = 8'h82;
    localparam logic [BYTE_W-1:0] OP_BRK_OFF = 8'h83;

    typedef enum logic [1:0] {
        PS_DATA,
        PS_OP,
        PS_LEN
    } pstate_e;

    typedef enum logic [2:0] {
        OPK_LITERAL,
        OPK_BRK_ON,
        OPK_BRK_OFF,
        OPK_DELAY,
        OPK_BAD
    } opkind_e;

    typedef struct packed {
        logic brk_on;
        logic brk_off;
        logic dly_load;
        logic bad;
    } act_t;

    function automatic opkind_e decode_op(input logic [BYTE_W-1:0] b);
        opkind_e k;
        case (b)
            ESC_CODE:   k = OPK_LITERAL;
            OP_BRK_ON:  k = OPK_BRK_ON;
            OP_BRK_OFF: k = OPK_BRK_OFF;
            OP_DELAY:   k = OPK_DELAY;
            default:    k = OPK_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/txc_parser.sv
module txc_parser
    import txc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    input  logic              hold,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output act_t              act,
    output logic              err
);

    pstate_e st_q, st_n;
    opkind_e op_k;
    logic    pass_ok;
    logic    err_q;

    assign op_k    = decode_op(in_data);
    assign pass_ok = out_ready && !hold;

    always_comb begin
        st_n      = st_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        act       = '0;
        case (st_q)
            PS_DATA: begin
                if (cmd_en && in_data == ESC_CODE) begin
                    in_ready = 1'b1;
                    if (in_valid) st_n = PS_OP;
                end else begin
                    out_valid = in_valid && !hold;
                    in_ready  = pass_ok;
                end
            end
            PS_OP: begin
                if (op_k == OPK_LITERAL) begin
                    out_valid = in_valid && !hold;
                    in_ready  = pass_ok;
                    if (in_valid && pass_ok) st_n = PS_DATA;
                end else begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        st_n = PS_DATA;
                        case (op_k)
                            OPK_BRK_ON:  act.brk_on  = 1'b1;
                            OPK_BRK_OFF: act.brk_off = 1'b1;
                            OPK_DELAY:   st_n        = PS_LEN;
                            default:     act.bad     = 1'b1;
                        endcase
                    end
                end
            end
            PS_LEN: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    act.dly_load = 1'b1;
                    st_n         = PS_DATA;
                end
            end
            default: st_n = PS_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_DATA;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            err_q <= act.bad;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/txc_break_ctl.sv
module txc_break_ctl (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic brk_o
);

    logic brk_q;

    always_ff @(posedge clk) begin
        if (rst)        brk_q <= 1'b0;
        else if (set_i) brk_q <= 1'b1;
        else if (clr_i) brk_q <= 1'b0;
    end

    assign brk_o = brk_q;

endmodule

// File: rtl/txc_delay_timer.sv
module txc_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             tick_i,
    output logic             busy_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                         cnt_q <= '0;
        else if (load_i)                 cnt_q <= len_i;
        else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - ONE;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/txc_interp.sv
module txc_interp
    import txc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              tick,
    output logic              brk_level,
    output logic              err
);

    act_t act;
    logic brk_q;
    logic dly_busy;
    logic hold;

    assign hold = brk_q || dly_busy;

    txc_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .cmd_en    (cmd_en),
        .hold      (hold),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .act       (act),
        .err       (err)
    );

    txc_break_ctl u_break (
        .clk   (clk),
        .rst   (rst),
        .set_i (act.brk_on),
        .clr_i (act.brk_off),
        .brk_o (brk_q)
    );

    txc_delay_timer #(.CNT_W(BYTE_W)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .load_i (act.dly_load),
        .len_i  (in_data),
        .tick_i (tick),
        .busy_o (dly_busy)
    );

    assign out_data  = in_data;
    assign brk_level = brk_q;

endmodule

// File: rtl/txc_interp_chk.sv
module txc_interp_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       brk_level,
    input logic       err
);

    p_no_data_in_break_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !brk_level);

    p_brk_rise_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_level) |-> $past(in_valid && in_ready && in_data == 8'h81));

    p_brk_fall_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_level) |-> $past(in_valid && in_ready && in_data == 8'h83));

    p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(in_valid && in_ready && in_data != 8'h00 && in_data != 8'h81
                      && in_data != 8'h82 && in_data != 8'h83));

    p_out_needs_in_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_valid);

    p_xfer_paired_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |-> (in_valid && in_ready));

endmodule

bind txc_interp txc_interp_chk u_chk (.*);

// File: tb/txc_interp_tb.sv
module txc_interp_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h55;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       tick = 1'b0;
    logic       brk_level;
    logic       err;

    int n_tests = 0;
    int n_fail  = 0;
    int err_cnt = 0;
    bit rand_bp = 0;
    bit tick_rand = 0;
    logic tick_req = 1'b0;

    logic [7:0] q_in[$];
    logic [7:0] q_got[$];
    logic [7:0] q_exp[$];

    always #10 clk = ~clk;

    txc_interp u_dut (
        .clk(clk), .rst(rst), .cmd_en(cmd_en),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .tick(tick), .brk_level(brk_level), .err(err)
    );

    always @(negedge clk) tick <= tick_rand ? 1'($urandom % 2) : tick_req;

    always @(negedge clk) begin
        #1;
        if (!rst && err) err_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        int guard = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        if (rand_bp) out_ready = ($urandom % 4) != 0;
        #1;
        while (!in_ready && guard < 3000) begin
            @(negedge clk);
            if (rand_bp) out_ready = ($urandom % 4) != 0;
            #1;
            guard++;
        end
        if (guard >= 3000) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10 byte %0h never accepted actual=0 expected=1", b);
        end else begin
            q_in.push_back(b);
            if (out_valid && out_ready) q_got.push_back(out_data);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic tick_burst(input int n);
        @(posedge clk);
        #1 tick_req = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_req = 1'b0;
    endtask

    function automatic int model(input bit en);
        int st = 0;
        int bad = 0;
        q_exp.delete();
        foreach (q_in[i]) begin
            logic [7:0] b = q_in[i];
            case (st)
                0: if (en && b == 8'h00) st = 1; else q_exp.push_back(b);
                1: begin
                    st = 0;
                    if (b == 8'h00) q_exp.push_back(b);
                    else if (b == 8'h82) st = 2;
                    else if (b != 8'h81 && b != 8'h83) bad++;
                end
                default: st = 0;
            endcase
        end
        return bad;
    endfunction

    task automatic gen_token();
        int r = $urandom % 5;
        logic [7:0] b;
        case (r)
            0: send(8'($urandom % 255 + 1));
            1: begin send(8'h00); send(8'h00); end
            2: begin
                send(8'h00); send(8'h81);
                if ($urandom % 2 == 1) begin
                    send(8'h00); send(8'h82); send(8'($urandom % 4));
                end
                send(8'h00); send(8'h83);
            end
            3: begin send(8'h00); send(8'h82); send(8'($urandom % 4)); end
            default: begin
                b = 8'($urandom);
                if (b == 8'h00 || b == 8'h81 || b == 8'h82 || b == 8'h83) b = 8'h42;
                send(8'h00); send(b);
            end
        endcase
    endtask

    task automatic random_run(input bit en);
        int e0;
        int bad;
        q_in.delete();
        q_got.delete();
        cmd_en = en;
        e0 = err_cnt;
        rand_bp = 1;
        tick_rand = 1;
        repeat (80) gen_token();
        rand_bp = 0;
        tick_rand = 0;
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        bad = model(en);
        check(en ? "R10 stream length (commands on)" : "R2 stream length", q_got.size(), q_exp.size());
        if (q_got.size() == q_exp.size())
            foreach (q_exp[i]) check(en ? "R10 stream byte" : "R2 stream byte", q_got[i], q_exp[i]);
        check("R8 error pulses in random run", err_cnt - e0, bad);
        check("R5 break released at end of run", brk_level, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 brk_level after reset", brk_level, 0);
        check("R1 err after reset", err, 0);
        check("R1 in_ready idle", in_ready, 1);
        check("R1 out_valid with no input", out_valid, 0);

        // R2: pass-through with commands off
        cmd_en = 1'b0;
        q_got.delete();
        send(8'h00);
        send(8'h81);
        check("R2 count", q_got.size(), 2);
        if (q_got.size() == 2) begin
            check("R2 zero byte", q_got[0], 8'h00);
            check("R2 0x81 byte", q_got[1], 8'h81);
        end
        check("R2 no break", brk_level, 0);

        // R3 escape, R7 literal
        cmd_en = 1'b1;
        q_got.delete();
        send(8'h00);
        check("R3 escape makes no output", q_got.size(), 0);
        send(8'h00);
        check("R7 literal count", q_got.size(), 1);
        if (q_got.size() == 1) check("R7 literal value", q_got[0], 8'h00);

        // R4 break on, data held
        send(8'h00);
        send(8'h81);
        check("R4 brk_level set", brk_level, 1);
        in_data = 8'h41;
        in_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check("R4 data held in_ready", in_ready, 0);
            check("R4 data held out_valid", out_valid, 0);
        end
        @(posedge clk); #1 in_valid = 1'b0;

        // R9 commands taken during break, R5 break off
        send(8'h00);
        check("R9 break still on after escape", brk_level, 1);
        send(8'h83);
        check("R5 brk_level cleared", brk_level, 0);
        q_got.delete();
        send(8'h41);
        check("R5 data flows after break", q_got.size(), 1);

        // R6 pause of 3 ticks
        tick_req = 1'b0;
        send(8'h00); send(8'h82); send(8'h03);
        in_data = 8'h42;
        in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check("R6 held before ticks", in_ready, 0);
        end
        tick_burst(2);
        @(negedge clk); #1;
        check("R6 held after 2 of 3 ticks", in_ready, 0);
        tick_burst(1);
        @(negedge clk); #1;
        check("R6 released after 3 ticks in_ready", in_ready, 1);
        check("R6 released after 3 ticks out_valid", out_valid, 1);
        check("R6 released data", out_data, 8'h42);
        @(posedge clk); #1 in_valid = 1'b0;

        // R6 zero length
        send(8'h00); send(8'h82); send(8'h00);
        in_data = 8'h43;
        in_valid = 1'b1;
        @(negedge clk); #1;
        check("R6 zero length no hold", in_ready, 1);
        check("R6 zero length out_valid", out_valid, 1);
        @(posedge clk); #1 in_valid = 1'b0;

        // R8 unknown code
        q_got.delete();
        send(8'h00);
        send(8'h44);
        @(negedge clk); #1;
        check("R8 err pulse high", err, 1);
        @(negedge clk); #1;
        check("R8 err pulse one cycle", err, 0);
        check("R8 bytes dropped", q_got.size(), 0);

        random_run(1'b0);
        random_run(1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule